// File: doc/BRIEF.md
# Shared Interrupt Priority Scanner

This block keeps the per-interrupt state of the shared interrupts of an interrupt distributor and finds, for every CPU, the highest-priority interrupt that may be signalled to it. Interrupts are numbered from 32 up to `NUM_IRQ-1`. Each one has a pending latch, a trigger mode (edge or level), the sampled input line, a group bit and a group-modifier bit, an enable bit, an active bit, an 8-bit priority and a target CPU index. A small control register holds three group enables and a security-disable bit.

Software-side logic writes state through a one-field-per-cycle write port and then asks for a rescan of a range of interrupts. The scanner walks the range one interrupt per clock. It works out which interrupts may be signalled one aligned 32-interrupt word at a time, and it keeps one best record (number and priority) per CPU. If a partial rescan cannot confirm a CPU's previous best, that best may have been withdrawn, so the scanner escalates to a full rescan from scratch before it reports completion with a one-cycle done pulse.

Top module: `spi_dist_scanner`

## Requirements
- R1: An interrupt is pending when its latch is set, or when its trigger mode is level (mode bit 0) and its input line is high. In edge mode (mode bit 1) a rising input sets the latch, which stays set after the line falls.
- R2: An interrupt is eligible only when it is pending, enabled, not active, and its group is enabled. Ineligible interrupts never update a best record.
- R3: Control bits are: bit 0 enables group 0, bit 1 enables non-secure group 1, bit 2 enables secure group 1, bit 3 is security-disable. Group bit 1 selects non-secure group 1; group bit 0 with modifier 1 selects secure group 1; both 0 select group 0.
- R4: While security-disable is set, every modifier bit is treated as 0.
- R5: A candidate replaces a CPU's best when its priority value is lower, or equal with an interrupt number lower than or equal to the recorded one.
- R6: An interrupt whose target index is not below `NUM_CPU` updates no record and keeps its pending state, so retargeting it later makes it visible.
- R7: After reset every best priority is 0xFF (no interrupt), every best number is all ones, and busy and done are low.
- R8: A scan request while idle raises busy on the next cycle; the scan takes one cycle per interrupt and done is high for exactly one cycle, `len` cycles after the request edge when no escalation occurs.
- R9: A partial rescan keeps a CPU's previous best unchanged when that best lies outside the scanned range and nothing better is found.
- R10: When a partial rescan finds no candidate for a CPU whose valid previous best lies inside the range, all best priorities are set to 0xFF and every shared interrupt is rescanned; done then comes `len + NUM_IRQ - 32` cycles after the request edge.
- R11: Write port field codes: 0 pending latch, 1 trigger mode, 2 group, 3 modifier, 4 enable, 5 active (all from data bit 0), 6 priority (data 7:0), 7 target (low data bits); the address is the absolute interrupt number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one interrupt field |
| cfg_field | input | 3 | Field code (R11) |
| cfg_irq | input | IRQ_W | Absolute interrupt number to write |
| cfg_data | input | 8 | Write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_data | input | 4 | Control value (R3 bit map) |
| irq_lines | input | NUM_IRQ-32 | Shared interrupt input lines, bit 0 is interrupt 32 |
| scan_req | input | 1 | Start a rescan |
| scan_start | input | IRQ_W | First interrupt number of the range |
| scan_len | input | IRQ_W | Number of interrupts in the range |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle completion pulse |
| best_irq | output | NUM_CPU*IRQ_W | Best interrupt number per CPU, CPU 0 in the low bits |
| best_prio | output | NUM_CPU*8 | Best priority per CPU, 0xFF meaning none |

## Verification
The assertions assume scan requests arrive only while the scanner is idle, with a start of at least 32, a non-zero length and a range ending inside the implemented interrupts, and that neither state writes nor line changes happen while a scan runs. The bench respects this by issuing every request from a task that waits for done, and by making all writes and line changes between scans. Priorities used by the stimulus stay below 0xFF so that a real candidate is never confused with the empty marker.

// File: rtl/spi_scan_pkg.sv
`timescale 1ns/1ps
package spi_scan_pkg;
  localparam int FIRST_SPI = 32;
  localparam int WORD_BITS = 32;
  localparam logic [7:0] PRIO_NONE = 8'hFF;

  typedef enum logic [2:0] {
    FLD_PEND = 3'd0,
    FLD_EDGE = 3'd1,
    FLD_GRP  = 3'd2,
    FLD_MOD  = 3'd3,
    FLD_EN   = 3'd4,
    FLD_ACT  = 3'd5,
    FLD_PRIO = 3'd6,
    FLD_TGT  = 3'd7
  } fld_e;

  typedef struct packed {
    logic sec_dis;
    logic en_g1s;
    logic en_g1ns;
    logic en_g0;
  } ctl_t;
endpackage

// File: rtl/spi_state_bank.sv
`timescale 1ns/1ps
module spi_state_bank
  import spi_scan_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int TGT_W   = 2,
  localparam int NUM_SPI = NUM_IRQ - FIRST_SPI,
  localparam int IRQ_W   = $clog2(NUM_IRQ + 1),
  localparam int SPI_W   = $clog2(NUM_SPI),
  localparam int WORD_W  = SPI_W - 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  fld_e               wr_fld,
  input  logic [IRQ_W-1:0]   wr_irq,
  input  logic [7:0]         wr_data,
  input  logic [NUM_SPI-1:0] irq_in,
  input  ctl_t               ctl,
  input  logic [WORD_W-1:0]  word_sel,
  input  logic [SPI_W-1:0]   rd_idx,
  output logic [WORD_BITS-1:0] elig_word,
  output logic [7:0]         rd_prio,
  output logic [TGT_W-1:0]   rd_tgt
);
  logic [NUM_SPI-1:0] pend_q, edge_q, grp_q, mod_q, en_q, act_q, lvl_q;
  logic [7:0]       prio_q [NUM_SPI];
  logic [TGT_W-1:0] tgt_q  [NUM_SPI];

  logic             wr_hit;
  logic [SPI_W-1:0] wr_idx;

  assign wr_hit = wr_en && (wr_irq >= IRQ_W'(FIRST_SPI)) && (wr_irq < IRQ_W'(NUM_IRQ));
  assign wr_idx = SPI_W'(wr_irq - IRQ_W'(FIRST_SPI));

  // single-bit state; a rising line in edge mode sets the latch
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      edge_q <= '0;
      grp_q  <= '0;
      mod_q  <= '0;
      en_q   <= '0;
      act_q  <= '0;
      lvl_q  <= '0;
    end else begin
      lvl_q  <= irq_in;
      pend_q <= pend_q | (edge_q & irq_in & ~lvl_q);
      if (wr_hit) begin
        case (wr_fld)
          FLD_PEND: pend_q[wr_idx] <= wr_data[0];
          FLD_EDGE: edge_q[wr_idx] <= wr_data[0];
          FLD_GRP:  grp_q[wr_idx]  <= wr_data[0];
          FLD_MOD:  mod_q[wr_idx]  <= wr_data[0];
          FLD_EN:   en_q[wr_idx]   <= wr_data[0];
          FLD_ACT:  act_q[wr_idx]  <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  // wide fields kept in plain arrays without reset (RAM-friendly)
  always_ff @(posedge clk) begin
    if (wr_hit && wr_fld == FLD_PRIO) prio_q[wr_idx] <= wr_data;
    if (wr_hit && wr_fld == FLD_TGT)  tgt_q[wr_idx]  <= wr_data[TGT_W-1:0];
  end

  assign rd_prio = prio_q[rd_idx];
  assign rd_tgt  = tgt_q[rd_idx];

  // eligibility of one aligned word of 32 interrupts
  for (genvar b = 0; b < WORD_BITS; b++) begin : g_elig
    logic [SPI_W-1:0] k;
    logic pnd, mod_eff, grp_on;
    assign k       = {word_sel, 5'(b)};
    assign pnd     = pend_q[k] | (~edge_q[k] & lvl_q[k]);
    assign mod_eff = mod_q[k] & ~ctl.sec_dis;
    assign grp_on  = (grp_q[k] & ctl.en_g1ns)
                   | (~grp_q[k] & mod_eff & ctl.en_g1s)
                   | (~grp_q[k] & ~mod_eff & ctl.en_g0);
    assign elig_word[b] = pnd & en_q[k] & ~act_q[k] & grp_on;
  end
endmodule

// File: rtl/spi_scan_engine.sv
`timescale 1ns/1ps
module spi_scan_engine
  import spi_scan_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  parameter int TGT_W   = 2,
  localparam int NUM_SPI = NUM_IRQ - FIRST_SPI,
  localparam int IRQ_W   = $clog2(NUM_IRQ + 1),
  localparam int SPI_W   = $clog2(NUM_SPI)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scan_req,
  input  logic [IRQ_W-1:0]         scan_start,
  input  logic [IRQ_W-1:0]         scan_len,
  input  logic [WORD_BITS-1:0]     elig_word,
  input  logic [7:0]               rd_prio,
  input  logic [TGT_W-1:0]         rd_tgt,
  output logic [SPI_W-1:0]         cur_idx,
  output logic                     busy,
  output logic                     done,
  output logic [NUM_CPU*IRQ_W-1:0] best_irq,
  output logic [NUM_CPU*8-1:0]     best_prio
);
  logic                 busy_q, done_q, full_q, first_q;
  logic [SPI_W-1:0]     cur_q, last_q;
  logic [IRQ_W-1:0]     lo_q, hi_q, cur_abs;
  logic [WORD_BITS-1:0] word_q;
  logic                 start_go, use_now, cand, last_cyc, escalate;
  logic [NUM_CPU-1:0]   take, stale, seen_q;
  logic [7:0]           bp_q [NUM_CPU];
  logic [IRQ_W-1:0]     bi_q [NUM_CPU];

  assign start_go = scan_req && !busy_q;
  assign cur_abs  = IRQ_W'(cur_q) + IRQ_W'(FIRST_SPI);
  assign use_now  = first_q || (cur_q[4:0] == 5'd0);
  assign cand     = busy_q && (use_now ? elig_word[cur_q[4:0]] : word_q[cur_q[4:0]]);
  assign last_cyc = busy_q && (cur_q == last_q);
  assign escalate = last_cyc && !full_q && (|stale);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign take[c] = cand && (rd_tgt == TGT_W'(c)) &&
                     ((rd_prio < bp_q[c]) || ((rd_prio == bp_q[c]) && (cur_abs <= bi_q[c])));
    assign stale[c] = !(seen_q[c] | take[c]) && (bp_q[c] != PRIO_NONE) &&
                      (bi_q[c] >= lo_q) && (bi_q[c] <= hi_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        bp_q[c]   <= PRIO_NONE;
        bi_q[c]   <= '1;
        seen_q[c] <= 1'b0;
      end else if (start_go) begin
        seen_q[c] <= 1'b0;
      end else if (escalate) begin
        bp_q[c]   <= PRIO_NONE;
      end else if (take[c]) begin
        bp_q[c]   <= rd_prio;
        bi_q[c]   <= cur_abs;
        seen_q[c] <= 1'b1;
      end
    end

    assign best_prio[c*8 +: 8]         = bp_q[c];
    assign best_irq[c*IRQ_W +: IRQ_W]  = bi_q[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      full_q  <= 1'b0;
      first_q <= 1'b0;
      cur_q   <= '0;
      last_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_go) begin
        busy_q  <= 1'b1;
        full_q  <= 1'b0;
        first_q <= 1'b1;
        cur_q   <= SPI_W'(scan_start - IRQ_W'(FIRST_SPI));
        last_q  <= SPI_W'(scan_start + scan_len - IRQ_W'(FIRST_SPI + 1));
        lo_q    <= scan_start;
        hi_q    <= scan_start + scan_len - IRQ_W'(1);
      end else if (busy_q) begin
        if (use_now) word_q <= elig_word;
        first_q <= 1'b0;
        if (last_cyc) begin
          if (escalate) begin
            full_q  <= 1'b1;
            first_q <= 1'b1;
            cur_q   <= '0;
            last_q  <= SPI_W'(NUM_SPI - 1);
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cur_q <= cur_q + SPI_W'(1);
        end
      end
    end
  end

  assign cur_idx = cur_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/spi_dist_scanner.sv
`timescale 1ns/1ps
module spi_dist_scanner
  import spi_scan_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  parameter int TGT_W   = 2,
  localparam int NUM_SPI = NUM_IRQ - FIRST_SPI,
  localparam int IRQ_W   = $clog2(NUM_IRQ + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_field,
  input  logic [IRQ_W-1:0]         cfg_irq,
  input  logic [7:0]               cfg_data,
  input  logic                     ctl_we,
  input  logic [3:0]               ctl_data,
  input  logic [NUM_SPI-1:0]       irq_lines,
  input  logic                     scan_req,
  input  logic [IRQ_W-1:0]         scan_start,
  input  logic [IRQ_W-1:0]         scan_len,
  output logic                     scan_busy,
  output logic                     scan_done,
  output logic [NUM_CPU*IRQ_W-1:0] best_irq,
  output logic [NUM_CPU*8-1:0]     best_prio
);
  localparam int SPI_W  = $clog2(NUM_SPI);
  localparam int WORD_W = SPI_W - 5;

  ctl_t                 ctl_q;
  logic [WORD_BITS-1:0] elig_word;
  logic [7:0]           rd_prio;
  logic [TGT_W-1:0]     rd_tgt;
  logic [SPI_W-1:0]     cur_idx;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_data);
  end

  spi_state_bank #(.NUM_IRQ(NUM_IRQ), .TGT_W(TGT_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we),
    .wr_fld    (fld_e'(cfg_field)),
    .wr_irq    (cfg_irq),
    .wr_data   (cfg_data),
    .irq_in    (irq_lines),
    .ctl       (ctl_q),
    .word_sel  (cur_idx[SPI_W-1:SPI_W-WORD_W]),
    .rd_idx    (cur_idx),
    .elig_word (elig_word),
    .rd_prio   (rd_prio),
    .rd_tgt    (rd_tgt)
  );

  spi_scan_engine #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .TGT_W(TGT_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .scan_req   (scan_req),
    .scan_start (scan_start),
    .scan_len   (scan_len),
    .elig_word  (elig_word),
    .rd_prio    (rd_prio),
    .rd_tgt     (rd_tgt),
    .cur_idx    (cur_idx),
    .busy       (scan_busy),
    .done       (scan_done),
    .best_irq   (best_irq),
    .best_prio  (best_prio)
  );
endmodule

// File: rtl/spi_dist_scanner_chk.sv
`timescale 1ns/1ps
module spi_dist_scanner_chk #(
  parameter int NUM_CPU = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 scan_req,
  input logic                 scan_busy,
  input logic                 scan_done,
  input logic [NUM_CPU*8-1:0] best_prio
);
  p_busy_after_req_r8: assert property (@(posedge clk) disable iff (rst)
    (!scan_busy && scan_req) |=> scan_busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> !scan_busy);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !scan_busy |=> $stable(best_prio[c*8 +: 8]));

    // only better candidates or the escalation reset may change a record
    p_prio_nonincr_r5: assert property (@(posedge clk) disable iff (rst)
      scan_busy |=> ((best_prio[c*8 +: 8] <= $past(best_prio[c*8 +: 8])) ||
                     (best_prio[c*8 +: 8] == 8'hFF)));
  end
endmodule

bind spi_dist_scanner spi_dist_scanner_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scan_req  (scan_req),
  .scan_busy (scan_busy),
  .scan_done (scan_done),
  .best_prio (best_prio)
);

// File: tb/spi_dist_scanner_bench.sv
`timescale 1ns/1ps
module spi_dist_scanner_bench;
  localparam int NI = 96, NC = 2, TW = 2, NS = NI - 32, IW = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0; logic [2:0] cfg_field = '0; logic [IW-1:0] cfg_irq = '0; logic [7:0] cfg_data = '0;
  logic ctl_we = 1'b0; logic [3:0] ctl_data = '0;
  logic [NS-1:0] irq_lines = '0;
  logic scan_req = 1'b0; logic [IW-1:0] scan_start = '0, scan_len = '0;
  logic scan_busy, scan_done;
  logic [NC*IW-1:0] best_irq;
  logic [NC*8-1:0] best_prio;

  spi_dist_scanner #(.NUM_IRQ(NI), .NUM_CPU(NC), .TGT_W(TW)) u_spi_dist_scanner (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  bit b_pend[NS], b_edge[NS], b_grp[NS], b_mod[NS], b_en[NS], b_act[NS], b_lvl[NS];
  int b_prio[NS], b_tgt[NS];
  int b_ctl = 0;
  int m_prio[NC], m_irq[NC];

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int fld, int irq, int data);
    @(negedge clk);
    cfg_we = 1; cfg_field = 3'(fld); cfg_irq = IW'(irq); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 0;
    if (irq >= 32 && irq < NI) begin
      case (fld)
        0: b_pend[irq-32] = data[0];
        1: b_edge[irq-32] = data[0];
        2: b_grp[irq-32]  = data[0];
        3: b_mod[irq-32]  = data[0];
        4: b_en[irq-32]   = data[0];
        5: b_act[irq-32]  = data[0];
        6: b_prio[irq-32] = data & 255;
        default: b_tgt[irq-32] = data % (1 << TW);
      endcase
    end
  endtask

  task automatic set_ctl(int v);
    @(negedge clk);
    ctl_we = 1; ctl_data = 4'(v);
    @(negedge clk);
    ctl_we = 0; b_ctl = v;
  endtask

  task automatic set_lines(logic [NS-1:0] v);
    @(negedge clk);
    irq_lines = v;
    for (int i = 0; i < NS; i++) begin
      if (v[i] && !b_lvl[i] && b_edge[i]) b_pend[i] = 1;
      b_lvl[i] = v[i];
    end
    @(negedge clk);
  endtask

  task automatic line(int irq, bit v);
    logic [NS-1:0] t;
    t = irq_lines; t[irq-32] = v;
    set_lines(t);
  endtask

  // R1..R4 eligibility from the stated rules
  function automatic bit m_elig(int i);
    bit pnd, me, gon;
    pnd = b_pend[i] | (!b_edge[i] & b_lvl[i]);
    me  = b_mod[i] & !b_ctl[3];
    if (b_grp[i]) gon = b_ctl[1];
    else if (me)  gon = b_ctl[2];
    else          gon = b_ctl[0];
    return pnd & b_en[i] & !b_act[i] & gon;
  endfunction

  task automatic m_range(int s, int l, ref bit seen[NC]);
    for (int n = s; n < s + l; n++) begin
      int t;
      t = b_tgt[n-32];
      if (m_elig(n-32) && t < NC) begin
        if (b_prio[n-32] < m_prio[t] || (b_prio[n-32] == m_prio[t] && n <= m_irq[t])) begin
          m_prio[t] = b_prio[n-32]; m_irq[t] = n; seen[t] = 1;
        end
      end
    end
  endtask

  task automatic m_scan(int s, int l, output int cyc);
    bit seen[NC];
    bit esc;
    for (int c = 0; c < NC; c++) seen[c] = 0;
    m_range(s, l, seen);
    esc = 0;
    for (int c = 0; c < NC; c++)
      if (!seen[c] && m_prio[c] != 255 && m_irq[c] >= s && m_irq[c] < s + l) esc = 1;
    cyc = l;
    if (esc) begin
      for (int c = 0; c < NC; c++) m_prio[c] = 255;
      m_range(32, NS, seen);
      cyc = l + NS;
    end
  endtask

  task automatic run_scan(string tag, int s, int l);
    int exp_cyc, n;
    m_scan(s, l, exp_cyc);
    @(negedge clk);
    scan_req = 1; scan_start = IW'(s); scan_len = IW'(l);
    @(posedge clk);
    @(negedge clk);
    scan_req = 0;
    chk({tag, " R8 busy after request"}, int'(scan_busy), 1);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!scan_done && n < 1000);
    chk({tag, " R8 R10 latency"}, n, exp_cyc);
    @(negedge clk);
    chk({tag, " R8 done single"}, int'(scan_done), 0);
    for (int c = 0; c < NC; c++) begin
      chk({tag, " best prio"}, int'(best_prio[c*8 +: 8]), m_prio[c]);
      chk({tag, " best irq"}, int'(best_irq[c*IW +: IW]), m_irq[c]);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      b_pend[i] = 0; b_edge[i] = 0; b_grp[i] = 0; b_mod[i] = 0;
      b_en[i] = 0; b_act[i] = 0; b_lvl[i] = 0; b_prio[i] = 0; b_tgt[i] = 0;
    end
    for (int c = 0; c < NC; c++) begin m_prio[c] = 255; m_irq[c] = 127; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R7 reset state
    for (int c = 0; c < NC; c++) begin
      chk("R7 reset prio", int'(best_prio[c*8 +: 8]), 255);
      chk("R7 reset irq", int'(best_irq[c*IW +: IW]), 127);
    end
    chk("R7 reset busy", int'(scan_busy), 0);
    chk("R7 reset done", int'(scan_done), 0);

    // R11 baseline configuration through the write port
    set_ctl(7);
    for (int n = 32; n < NI; n++) begin
      wr(4, n, 1); wr(6, n, 8'h80); wr(7, n, 0); wr(2, n, 1); wr(1, n, 1);
    end

    // R5 priority and tie order
    wr(0, 40, 1); wr(6, 40, 8'h30);
    wr(0, 50, 1); wr(6, 50, 8'h30);
    wr(0, 60, 1); wr(6, 60, 8'h20); wr(7, 60, 1);
    run_scan("R5", 32, 64);
    chk("R5 tie lower number", int'(best_irq[0 +: IW]), 40);
    chk("R5 cpu1 best", int'(best_irq[IW +: IW]), 60);

    // R9 partial scan outside the best
    run_scan("R9", 64, 32);
    chk("R9 best kept", int'(best_irq[0 +: IW]), 40);

    // R10 escalation after the best becomes active (R2)
    wr(5, 40, 1);
    run_scan("R10", 32, 16);
    chk("R10 R2 new best", int'(best_irq[0 +: IW]), 50);

    // R6 unimplemented target
    wr(6, 45, 8'h05); wr(7, 45, 3); wr(0, 45, 1);
    run_scan("R6", 32, 64);
    chk("R6 no update", int'(best_irq[0 +: IW]), 50);
    wr(7, 45, 0);
    run_scan("R6 retarget", 40, 8);
    chk("R6 still pending", int'(best_irq[0 +: IW]), 45);

    // R3 group mapping
    wr(0, 45, 0);
    wr(2, 70, 0); wr(3, 70, 1); wr(6, 70, 8'h02); wr(0, 70, 1);
    set_ctl(4'b0011);
    run_scan("R3 g1s off", 32, 64);
    chk("R3 secure g1 masked", int'(best_irq[0 +: IW]), 50);
    set_ctl(4'b0111);
    run_scan("R3 g1s on", 64, 32);
    chk("R3 secure g1 taken", int'(best_irq[0 +: IW]), 70);

    // R4 security disable
    set_ctl(4'b1011);
    run_scan("R4 as group0", 64, 32);
    chk("R4 modifier ignored", int'(best_irq[0 +: IW]), 70);
    set_ctl(4'b1010);
    run_scan("R4 g0 off", 64, 32);
    chk("R4 masked as group0", int'(best_irq[0 +: IW]), 50);

    // R1 level and edge
    set_ctl(7);
    wr(1, 85, 0); wr(6, 85, 8'h01);
    line(85, 1);
    run_scan("R1 level high", 80, 16);
    chk("R1 level pending", int'(best_irq[0 +: IW]), 85);
    line(85, 0);
    run_scan("R1 level low", 80, 16);
    wr(6, 86, 8'h00);
    line(86, 1); line(86, 0);
    run_scan("R1 edge latch", 80, 16);
    chk("R1 edge latched", int'(best_irq[0 +: IW]), 86);
    wr(4, 86, 0);
    run_scan("R2 disabled", 80, 16);

    // sweep of mixed configurations against the arithmetic model
    for (int it = 0; it < 24; it++) begin
      logic [NS-1:0] lv;
      int s, l;
      for (int n = 32; n < NI; n++) begin
        wr(0, n, $urandom % 4 == 0); wr(1, n, $urandom % 2);
        wr(2, n, $urandom % 2); wr(3, n, $urandom % 2);
        wr(4, n, $urandom % 4 != 0); wr(5, n, $urandom % 5 == 0);
        wr(6, n, $urandom % 12); wr(7, n, $urandom % 4);
      end
      set_ctl($urandom % 16);
      lv = {$urandom, $urandom};
      set_lines(lv);
      run_scan("R10 sweep full", 32, NS);
      s = 32 + $urandom % NS;
      l = 1 + $urandom % (NI - s);
      run_scan("R9 sweep partial", s, l);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule